// File: doc/BRIEF.md
# Retired-Instruction Timer with Compare Interrupt

This block keeps a 32-bit counter that moves forward by the number of instructions a core retires in each clock (zero to four), and a 32-bit compare value. When an update carries the counter from below the compare value to at or above it, the block sends a one-cycle set request to the interrupt controller. The check uses an extra carry bit, so the request still fires when the step jumps past the compare value and when the 32-bit counter wraps during the step.

Software reads and writes the counter and the compare value through a simple register port. A compare write sends a one-cycle clear request, which acknowledges the interrupt. A 64-bit read-only total of all retired instructions sits next to them and is read as two 32-bit halves.

Top module: `insn_timer`

## Requirements
- R1: After reset the counter, the compare value and the 64-bit total read as zero, and `irq_set` and `irq_clr` are low.
- R2: With no counter write, the counter increases each clock by `retire_cnt`. Values 5 to 7 on `retire_cnt` count as 4, and the counter wraps modulo 2^32.
- R3: `irq_set` is high for exactly one clock, the clock after an update in which the old counter is below compare and the old counter plus the increment, taken as a 33-bit sum, is at or above compare. This covers landing exactly on compare and stepping over it.
- R4: A crossing whose 33-bit sum passes 2^32 still raises `irq_set`, and the counter then holds the wrapped value.
- R5: No request is raised when the counter is already at or above compare, or when compare is zero.
- R6: A write with `wr_sel`=1 loads compare and raises `irq_clr` for one clock, the clock after the write. No crossing is reported for that clock, but the counter still advances.
- R7: A write with `wr_sel`=0 loads the counter directly. The increment is dropped for that clock, no crossing is reported, and `irq_clr` stays low.
- R8: The 64-bit total adds the clamped `retire_cnt` every clock, whatever is written. Writes with `wr_sel`=2 or 3 change nothing.
- R9: `rd_data` shows, combinationally from `rd_sel`: 0 = counter, 1 = compare, 2 = total bits 31:0, 3 = total bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_cnt | input | 3 | Instructions retired this clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written (0 counter, 1 compare) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register read |
| rd_data | output | 32 | Read data |
| irq_set | output | 1 | One-cycle timer-pending set request |
| irq_clr | output | 1 | One-cycle timer-pending clear request |

## Verification
Two things can happen in the same clock: a retirement step that would cross compare, and a software write to the counter or to compare. The bench sets up states where the next step crosses compare, then issues a counter write or a compare write in that same clock. The reference model decides the outcome. A compare write must give `irq_clr` with no `irq_set`, while the counter still advances. A counter write must give neither request and must load the written value.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT   = 2'd0,
    SEL_COMPARE = 2'd1,
    SEL_TOT_LO  = 2'd2,
    SEL_TOT_HI  = 2'd3
  } tmr_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_accum.sv
module tmr_accum #(
  parameter int W     = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [W-1:0]     ld_val,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = ld_en || (inc != '0);
    q_d  = ld_en ? ld_val : (q + W'(inc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/tmr_cross_detect.sv
module tmr_cross_detect #(
  parameter int W     = 32,
  parameter int INC_W = 3
) (
  input  logic             en,
  input  logic [W-1:0]     old_val,
  input  logic [W-1:0]     cmp_val,
  input  logic [INC_W-1:0] inc,
  output logic             hit
);
  localparam int SW = W + 1;
  logic [SW-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, old_val} + SW'(inc);
    hit      = en && (old_val < cmp_val) && (wide_sum >= {1'b0, cmp_val});
  end
endmodule

// File: rtl/insn_timer.sv
module insn_timer #(
  parameter int CNT_W   = 32,
  parameter int TOT_W   = 64,
  parameter int RET_W   = 3,
  parameter int MAX_RET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_set,
  output logic             irq_clr
);
  import timer_pkg::*;

  localparam logic [RET_W-1:0] RET_CAP = RET_W'(MAX_RET);

  logic             rst_sync_n;
  logic [RET_W-1:0] inc_c;
  logic             wr_cnt, wr_cmp;
  logic [CNT_W-1:0] count_q;
  logic [TOT_W-1:0] total_q;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             cross_hit;
  logic             set_d, clr_d;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    inc_c  = (retire_cnt > RET_CAP) ? RET_CAP : retire_cnt;
    wr_cnt = wr_en && (tmr_sel_e'(wr_sel) == SEL_COUNT);
    wr_cmp = wr_en && (tmr_sel_e'(wr_sel) == SEL_COMPARE);
    cmp_d  = wr_data;
  end

  tmr_accum #(.W(CNT_W), .INC_W(RET_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld_en  (wr_cnt),
    .ld_val (wr_data),
    .inc    (inc_c),
    .q      (count_q)
  );

  tmr_accum #(.W(TOT_W), .INC_W(RET_W)) u_total (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ld_en  (1'b0),
    .ld_val ({TOT_W{1'b0}}),
    .inc    (inc_c),
    .q      (total_q)
  );

  tmr_cross_detect #(.W(CNT_W), .INC_W(RET_W)) u_cross (
    .en      (!wr_cnt && !wr_cmp),
    .old_val (count_q),
    .cmp_val (cmp_q),
    .inc     (inc_c),
    .hit     (cross_hit)
  );

  always_comb begin
    set_d = cross_hit;
    clr_d = wr_cmp;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cmp_q <= '0;
    else if (wr_cmp)  cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_set <= 1'b0;
      irq_clr <= 1'b0;
    end else begin
      irq_set <= set_d;
      irq_clr <= clr_d;
    end
  end

  always_comb begin
    unique case (tmr_sel_e'(rd_sel))
      SEL_COUNT:   rd_data = count_q;
      SEL_COMPARE: rd_data = cmp_q;
      SEL_TOT_LO:  rd_data = CNT_W'(total_q);
      default:     rd_data = CNT_W'(total_q >> CNT_W);
    endcase
  end
endmodule

// File: rtl/insn_timer_chk.sv
module insn_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int TOT_W   = 64,
  parameter int RET_W   = 3,
  parameter int MAX_RET = 4
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [RET_W-1:0] retire_cnt,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] wr_data,
  input logic             irq_set,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count_q,
  input logic [TOT_W-1:0] total_q
);
  AST_CLR_ON_CMP_WR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == 2'd1) |=> irq_clr);                                   // R6
  AST_CLR_ONLY_CMP_WR: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && wr_sel == 2'd1) |=> !irq_clr);                                 // R7
  AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_set |=> !irq_set);                                                    // R3
  AST_NO_SET_ON_WR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_sel[1]) |=> !irq_set);                                      // R7
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == 2'd0) |=> (count_q == $past(wr_data)));               // R7
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!(wr_en && wr_sel == 2'd0) && retire_cnt == '0) |=> $stable(count_q));   // R2
  AST_TOT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((total_q - $past(total_q)) <= TOT_W'(MAX_RET)));                // R8
endmodule

bind insn_timer insn_timer_chk #(
  .CNT_W(CNT_W), .TOT_W(TOT_W), .RET_W(RET_W), .MAX_RET(MAX_RET)
) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .retire_cnt (retire_cnt),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .irq_set    (irq_set),
  .irq_clr    (irq_clr),
  .count_q    (count_q),
  .total_q    (total_q)
);

// File: tb/insn_timer_bench.sv
module insn_timer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  retire_cnt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_set, irq_clr;

  int compared = 0;
  int mismatched = 0;

  bit [31:0] m_cnt = 0;
  bit [31:0] m_cmp = 0;
  bit [63:0] m_tot = 0;

  always #2.5 clk = ~clk;

  insn_timer u_insn_timer (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_set(irq_set), .irq_clr(irq_clr)
  );

  function automatic bit [31:0] model_read(input int sel);
    case (sel)
      0: return m_cnt;
      1: return m_cmp;
      2: return m_tot[31:0];
      default: return m_tot[63:32];
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int r, input bit we, input int ws,
                     input bit [31:0] wd, input int rs, input string tag);
    int  inc;
    bit  w_cnt, w_cmp, exp_set, exp_clr;
    inc   = (r > 4) ? 4 : r;
    w_cnt = we && ws == 0;
    w_cmp = we && ws == 1;
    exp_set = !w_cnt && !w_cmp && (m_cnt < m_cmp) &&
              ((longint'(m_cnt) + inc) >= longint'(m_cmp));
    exp_clr = w_cmp;
    retire_cnt = 3'(r);
    wr_en = we; wr_sel = 2'(ws); wr_data = wd; rd_sel = 2'(rs);
    @(posedge clk);
    @(negedge clk);
    if (w_cnt) m_cnt = wd;
    else       m_cnt = m_cnt + 32'(inc);
    if (w_cmp) m_cmp = wd;
    m_tot = m_tot + 64'(inc);
    check(tag, "irq_set", longint'(irq_set), longint'(exp_set));
    check(tag, "irq_clr", longint'(irq_clr), longint'(exp_clr));
    check(tag, $sformatf("rd_data[sel %0d]", rs), longint'(rd_data),
          longint'(model_read(rs)));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, i % 4, tag);
  endtask

  initial begin
    #1000000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "irq_set in reset", longint'(irq_set), 0);
    check("R1", "irq_clr in reset", longint'(irq_clr), 0);
    rst_n = 1'b1;
    // R1: all registers read zero after reset
    idle(8, "R1");

    // R2: counting by retire amount, with clamp of 5..7 to 4
    cyc(1, 0, 0, 0, 0, "R2");
    cyc(3, 0, 0, 0, 0, "R2");
    cyc(7, 0, 0, 0, 0, "R2");
    cyc(5, 0, 0, 0, 2, "R2");

    // R3: step over compare (9 -> 12 across 10)
    cyc(0, 1, 0, 32'd0, 0, "R7");
    cyc(0, 1, 1, 32'd10, 1, "R6");
    for (int i = 0; i < 4; i++) cyc(3, 0, 0, 0, 0, "R3");
    idle(2, "R3");
    // R3: exact landing (8 + 4 = 12)
    cyc(0, 1, 0, 32'd8, 0, "R7");
    cyc(0, 1, 1, 32'd12, 1, "R6");
    cyc(4, 0, 0, 0, 0, "R3");
    idle(2, "R3");

    // R4: crossing through 32-bit wrap
    cyc(0, 1, 1, 32'hFFFF_FFFF, 1, "R6");
    cyc(0, 1, 0, 32'hFFFF_FFFE, 0, "R7");
    cyc(4, 0, 0, 0, 0, "R4");
    idle(2, "R4");

    // R5: already past compare, and compare zero
    cyc(0, 1, 1, 32'd10, 1, "R6");
    cyc(0, 1, 0, 32'd20, 0, "R7");
    for (int i = 0; i < 3; i++) cyc(4, 0, 0, 0, 0, "R5");
    cyc(0, 1, 1, 32'd0, 1, "R6");
    cyc(0, 1, 0, 32'hFFFF_FFFD, 0, "R7");
    for (int i = 0; i < 3; i++) cyc(4, 0, 0, 0, 0, "R5");

    // R6: compare write collides with a crossing step
    cyc(0, 1, 0, 32'd100, 0, "R7");
    cyc(0, 1, 1, 32'd102, 1, "R6");
    cyc(4, 1, 1, 32'd500, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R6");
    // R7: counter write collides with a crossing step
    cyc(0, 1, 0, 32'd498, 0, "R7");
    cyc(4, 1, 0, 32'd50, 0, "R7");
    idle(2, "R7");

    // R8: writes to total halves ignored, total keeps accumulating
    cyc(2, 1, 2, 32'hDEAD_BEEF, 2, "R8");
    cyc(2, 1, 3, 32'hCAFE_F00D, 3, "R8");
    cyc(0, 0, 0, 0, 2, "R8");
    cyc(0, 0, 0, 0, 3, "R8");

    // R9 with R3/R6/R7: mixed traffic across all read selections
    for (int i = 0; i < 2000; i++) begin
      int r, ws, rs;
      bit we;
      r  = $urandom % 8;
      we = ($urandom % 6) == 0;
      ws = $urandom % 4;
      rs = $urandom % 4;
      cyc(r, we, ws, m_cnt + 32'($urandom % 24), rs, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule